// File: doc/BRIEF.md
# Serial Increment-Echo Loopback

This block sits on an asynchronous serial line and returns each received character to the sender only when asked, with its code raised by one. Frames use eight data bits, one stop bit and no parity, sent least significant bit first on a line that rests high. A free-running divider produces a single-cycle enable pulse at sixteen times the bit rate. The receiver and the transmitter both advance on that pulse, so the whole block runs in one clock domain. With the default divide of 163 on a 50 MHz clock, the line runs at about 19,200 baud.

Every byte that arrives with a good stop bit goes into a small receive queue. The oldest entry in that queue is always shown on an 8-bit output, for example to drive a row of LEDs. A clean one-cycle request pulse takes that oldest entry out of the receive queue and, in the same cycle, places the entry plus one into a transmit queue. The transmitter sends from the transmit queue one frame after another.

Top module: `uart_echo_loop`

## Requirements
- R1: After reset `serial_out` is 1, `frame_err` is 0 and `rx_head` is 0x00. `serial_out` is 1 whenever no frame is being sent.
- R2: Every transmitted data bit lasts exactly OVS*CLK_DIV clock cycles, because the enable pulse comes once every CLK_DIV cycles and each bit lasts OVS pulses.
- R3: A frame is received as a low start bit, then data bit 0 through bit 7, then a high stop bit, with each bit sampled near its middle. The received byte appears on `rx_head` while it is the oldest entry in the receive queue.
- R4: If the stop bit is sampled low, the byte is discarded and `frame_err` goes high for exactly one clock cycle.
- R5: A low pulse on `serial_in` that is shorter than about half a bit is rejected during start confirmation. It stores no byte and raises no error.
- R6: A one-cycle `echo_req` removes the oldest received byte and queues that byte plus one for transmission. The byte is sent as a low start bit, bit 0 first, then a high stop bit (0x61 is returned as 0x62).
- R7: The increment wraps around: a received 0xFF is returned as 0x00.
- R8: An `echo_req` while the receive queue is empty has no effect, and no frame is sent.
- R9: The receive queue holds RX_DEPTH bytes. A byte that completes while the queue is full is dropped, and the queued bytes are kept in order.
- R10: While the transmit queue is full, `echo_req` neither removes nor queues anything, so `rx_head` keeps its value and no byte is lost. Echoes leave in the order they were requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serial_in | input | 1 | Serial receive line, idle high |
| echo_req | input | 1 | One-cycle request to echo the oldest received byte plus one |
| serial_out | output | 1 | Serial transmit line, idle high |
| rx_head | output | 8 | Oldest byte in the receive queue |
| frame_err | output | 1 | One-cycle pulse when a frame ends with a low stop bit |

## Verification
The hardest state to reach from the ports is a full transmit queue, because the transmitter drains the queue at the same rate that new bytes can arrive. The bench builds the block with a two-entry transmit queue. It first loads four bytes into the receive queue. It then sends four requests a few cycles apart: the first request goes straight into the transmitter's shift register, the next two fill the queue, and the fourth must be refused. The bench checks the refusal through `rx_head`, and then checks the order of the echoes on the serial output.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;
endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
    parameter int DIV = 163
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (s_q.cnt == CW'(DIV - 1)) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW:0]             wr;
        logic [AW:0]             rd;
    } fifo_st_t;

    fifo_st_t s_d, s_q;

    always_comb begin
        empty = (s_q.wr == s_q.rd);
        full  = (s_q.wr[AW-1:0] == s_q.rd[AW-1:0]) && (s_q.wr[AW] != s_q.rd[AW]);
        dout  = s_q.mem[s_q.rd[AW-1:0]];
        s_d   = s_q;
        if (push && !full) begin
            s_d.mem[s_q.wr[AW-1:0]] = din;
            s_d.wr                  = s_q.wr + 1'b1;
        end
        if (pop && !empty) begin
            s_d.rd = s_q.rd + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_echo_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int TW  = $clog2(OVS);
    localparam int BIW = $clog2(BYTE_W);
    localparam int MID = OVS / 2 - 2;

    typedef struct packed {
        rx_state_e         state;
        logic [TW-1:0]     tcnt;
        logic [BIW-1:0]    bidx;
        logic [BYTE_W-1:0] shreg;
        logic              sync1;
        logic              sync2;
        logic              prev;
        logic              valid;
        logic              err;
    } rx_st_t;

    rx_st_t s_d, s_q;
    logic   line;

    always_comb begin
        line      = s_q.sync2;
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.err   = 1'b0;
        s_d.sync1 = rx_i;
        s_d.sync2 = s_q.sync1;
        s_d.prev  = s_q.sync2;
        case (s_q.state)
            RX_IDLE: begin
                if (s_q.prev && !line) begin
                    s_d.state = RX_START;
                    s_d.tcnt  = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (s_q.tcnt == TW'(MID)) begin
                        s_d.tcnt  = '0;
                        s_d.bidx  = '0;
                        s_d.state = line ? RX_IDLE : RX_DATA;
                    end else begin
                        s_d.tcnt = s_q.tcnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (s_q.tcnt == TW'(OVS - 1)) begin
                        s_d.tcnt  = '0;
                        s_d.shreg = {line, s_q.shreg[BYTE_W-1:1]};
                        if (s_q.bidx == BIW'(BYTE_W - 1)) s_d.state = RX_STOP;
                        else                              s_d.bidx  = s_q.bidx + 1'b1;
                    end else begin
                        s_d.tcnt = s_q.tcnt + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (s_q.tcnt == TW'(OVS - 1)) begin
                        s_d.valid = line;
                        s_d.err   = !line;
                        s_d.state = RX_IDLE;
                    end else begin
                        s_d.tcnt = s_q.tcnt + 1'b1;
                    end
                end
            end
            default: s_d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= RX_IDLE;
            s_q.sync1 <= 1'b1;
            s_q.sync2 <= 1'b1;
            s_q.prev  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign byte_o  = s_q.shreg;
    assign valid_o = s_q.valid;
    assign err_o   = s_q.err;
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_echo_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              have_data,
    input  logic [BYTE_W-1:0] data_i,
    output logic              pop_o,
    output logic              tx_o,
    output logic              idle_o
);
    localparam int TW  = $clog2(OVS);
    localparam int BIW = $clog2(BYTE_W);

    typedef struct packed {
        tx_state_e         state;
        logic [TW-1:0]     tcnt;
        logic [BIW-1:0]    bidx;
        logic [BYTE_W-1:0] shreg;
        logic              out;
        logic              pop;
    } tx_st_t;

    tx_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.pop = 1'b0;
        case (s_q.state)
            TX_IDLE: begin
                s_d.out = 1'b1;
                if (have_data && !s_q.pop) begin
                    s_d.pop   = 1'b1;
                    s_d.shreg = data_i;
                    s_d.tcnt  = '0;
                    s_d.out   = 1'b0;
                    s_d.state = TX_START;
                end
            end
            TX_START: begin
                if (tick) begin
                    if (s_q.tcnt == TW'(OVS - 1)) begin
                        s_d.tcnt  = '0;
                        s_d.bidx  = '0;
                        s_d.out   = s_q.shreg[0];
                        s_d.state = TX_DATA;
                    end else begin
                        s_d.tcnt = s_q.tcnt + 1'b1;
                    end
                end
            end
            TX_DATA: begin
                if (tick) begin
                    if (s_q.tcnt == TW'(OVS - 1)) begin
                        s_d.tcnt = '0;
                        if (s_q.bidx == BIW'(BYTE_W - 1)) begin
                            s_d.out   = 1'b1;
                            s_d.state = TX_STOP;
                        end else begin
                            s_d.bidx  = s_q.bidx + 1'b1;
                            s_d.shreg = s_q.shreg >> 1;
                            s_d.out   = s_q.shreg[1];
                        end
                    end else begin
                        s_d.tcnt = s_q.tcnt + 1'b1;
                    end
                end
            end
            TX_STOP: begin
                if (tick) begin
                    if (s_q.tcnt == TW'(OVS - 1)) begin
                        s_d.tcnt  = '0;
                        s_d.state = TX_IDLE;
                    end else begin
                        s_d.tcnt = s_q.tcnt + 1'b1;
                    end
                end
            end
            default: s_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= TX_IDLE;
            s_q.out   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign pop_o  = s_q.pop;
    assign tx_o   = s_q.out;
    assign idle_o = (s_q.state == TX_IDLE);
endmodule

// File: rtl/uart_echo_loop.sv
module uart_echo_loop
    import uart_echo_pkg::*;
#(
    parameter int CLK_DIV  = 163,
    parameter int OVS      = 16,
    parameter int RX_DEPTH = 4,
    parameter int TX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_in,
    input  logic              echo_req,
    output logic              serial_out,
    output logic [BYTE_W-1:0] rx_head,
    output logic              frame_err
);
    logic              tick;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_wr;
    logic              rx_push;
    logic              rx_empty;
    logic              rx_full;
    logic              echo_go;
    logic [BYTE_W-1:0] echo_byte;
    logic [BYTE_W-1:0] tx_byte;
    logic              tx_empty;
    logic              tx_full;
    logic              tx_pop;
    logic              tx_idle;

    uart_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    uart_rx_core #(.OVS(OVS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rx_i    (serial_in),
        .byte_o  (rx_byte),
        .valid_o (rx_wr),
        .err_o   (frame_err)
    );

    assign rx_push = rx_wr && !rx_full;

    byte_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) u_rx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .din   (rx_byte),
        .pop   (echo_go),
        .dout  (rx_head),
        .empty (rx_empty),
        .full  (rx_full)
    );

    always_comb begin
        echo_go   = echo_req && !rx_empty && !tx_full;
        echo_byte = rx_head + 1'b1;
    end

    byte_fifo #(.DEPTH(TX_DEPTH), .W(BYTE_W)) u_tx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (echo_go),
        .din   (echo_byte),
        .pop   (tx_pop),
        .dout  (tx_byte),
        .empty (tx_empty),
        .full  (tx_full)
    );

    uart_tx_core #(.OVS(OVS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .have_data (!tx_empty),
        .data_i    (tx_byte),
        .pop_o     (tx_pop),
        .tx_o      (serial_out),
        .idle_o    (tx_idle)
    );
endmodule

// File: rtl/uart_echo_loop_checks.sv
module uart_echo_loop_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       echo_req,
    input logic       serial_out,
    input logic       frame_err,
    input logic       rx_empty,
    input logic       rx_wr,
    input logic       tx_full,
    input logic       tx_idle,
    input logic       echo_go,
    input logic [7:0] rx_head
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> serial_out);

    assert_head_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_empty && !echo_go) |=> $stable(rx_head));

    assert_err_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    assert_err_no_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_err, rx_wr}));

    assert_empty_req_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (echo_req && rx_empty) |-> !echo_go);

    assert_full_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !echo_go);
endmodule

bind uart_echo_loop uart_echo_loop_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .echo_req   (echo_req),
    .serial_out (serial_out),
    .frame_err  (frame_err),
    .rx_empty   (rx_empty),
    .rx_wr      (rx_wr),
    .tx_full    (tx_full),
    .tx_idle    (tx_idle),
    .echo_go    (echo_go),
    .rx_head    (rx_head)
);

// File: tb/uart_echo_loop_bench.sv
module uart_echo_loop_bench;
    localparam int DIV = 4;
    localparam int OVS = 16;
    localparam int P   = DIV * OVS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       serial_in = 1'b1;
    logic       echo_req = 1'b0;
    logic       serial_out;
    logic [7:0] rx_head;
    logic       frame_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] got [0:63];
    bit         got_stop [0:63];
    int         got_n  = 0;
    int         rd_idx = 0;
    int         err_cycles = 0;
    int         err_rises  = 0;
    bit         mon_en = 1'b0;

    always #5 clk = ~clk;

    uart_echo_loop #(
        .CLK_DIV  (DIV),
        .OVS      (OVS),
        .RX_DEPTH (4),
        .TX_DEPTH (2)
    ) u_uart_echo_loop (
        .clk        (clk),
        .rst_n      (rst_n),
        .serial_in  (serial_in),
        .echo_req   (echo_req),
        .serial_out (serial_out),
        .rx_head    (rx_head),
        .frame_err  (frame_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Decoder for the transmit line, sampling at the middle of each bit.
    initial begin
        logic prev_so;
        logic [7:0] b;
        prev_so = 1'b1;
        forever begin
            @(negedge clk);
            if (mon_en && prev_so && !serial_out) begin
                repeat (P / 2) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    repeat (P) @(negedge clk);
                    b[i] = serial_out;
                end
                repeat (P) @(negedge clk);
                got[got_n]      = b;
                got_stop[got_n] = serial_out;
                got_n++;
            end
            prev_so = serial_out;
        end
    end

    initial begin
        logic prev_e;
        prev_e = 1'b0;
        forever begin
            @(negedge clk);
            if (mon_en && frame_err) err_cycles++;
            if (mon_en && frame_err && !prev_e) err_rises++;
            prev_e = frame_err;
        end
    end

    task automatic send_byte(input logic [7:0] b, input logic stop_bit);
        @(negedge clk);
        serial_in = 1'b0;
        repeat (P) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            serial_in = b[i];
            repeat (P) @(negedge clk);
        end
        serial_in = stop_bit;
        repeat (P) @(negedge clk);
        serial_in = 1'b1;
        repeat (P) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk);
        echo_req = 1'b1;
        @(negedge clk);
        echo_req = 1'b0;
    endtask

    task automatic expect_echo(input logic [7:0] exp, input string tag);
        int waited;
        waited = 0;
        while (got_n <= rd_idx && waited < 30 * P) begin
            @(negedge clk);
            waited++;
        end
        if (got_n <= rd_idx) begin
            check({tag, " echo present"}, 0, 1);
        end else begin
            check({tag, " echo value"}, got[rd_idx], exp);
            check({tag, " stop bit high"}, got_stop[rd_idx], 1);
            rd_idx++;
        end
    endtask

    task automatic expect_no_echo(input string tag);
        repeat (14 * P) @(negedge clk);
        check({tag, " no frame sent"}, got_n, rd_idx);
    endtask

    task automatic test_reset();
        check("R1 serial_out after reset", serial_out, 1);
        check("R1 frame_err after reset", frame_err, 0);
        check("R1 rx_head after reset", rx_head, 8'h00);
    endtask

    task automatic test_echo_basic();
        send_byte(8'h61, 1'b1);
        check("R3 rx_head shows 0x61", rx_head, 8'h61);
        pulse_req();
        expect_echo(8'h62, "R6 0x61");
        send_byte(8'hA5, 1'b1);
        check("R3 rx_head shows 0xA5", rx_head, 8'hA5);
        pulse_req();
        expect_echo(8'hA6, "R6 0xA5");
        check("R1 line idle after echo", serial_out, 1);
    endtask

    task automatic test_wrap();
        send_byte(8'hFF, 1'b1);
        check("R3 rx_head shows 0xFF", rx_head, 8'hFF);
        pulse_req();
        expect_echo(8'h00, "R7 wrap");
    endtask

    task automatic test_bit_time();
        int width;
        send_byte(8'h54, 1'b1);
        pulse_req();
        @(negedge clk);
        while (serial_out) @(negedge clk);
        while (!serial_out) @(negedge clk);
        width = 0;
        while (serial_out && width < 4 * P) begin
            @(negedge clk);
            width++;
        end
        check("R2 data bit width", width, P);
        expect_echo(8'h55, "R2 0x54");
    endtask

    task automatic test_empty_req();
        pulse_req();
        expect_no_echo("R8 request on empty queue");
    endtask

    task automatic test_frame_err();
        int rises0, cyc0;
        rises0 = err_rises;
        cyc0   = err_cycles;
        send_byte(8'h3C, 1'b0);
        check("R4 one error pulse", err_rises - rises0, 1);
        check("R4 pulse one cycle wide", err_cycles - cyc0, 1);
        pulse_req();
        expect_no_echo("R4 bad frame dropped");
    endtask

    task automatic test_glitch();
        int rises0;
        rises0 = err_rises;
        @(negedge clk);
        serial_in = 1'b0;
        repeat (2 * DIV) @(negedge clk);
        serial_in = 1'b1;
        repeat (2 * P) @(negedge clk);
        send_byte(8'h30, 1'b1);
        pulse_req();
        expect_echo(8'h31, "R5 byte after glitch");
        pulse_req();
        expect_no_echo("R5 glitch stored nothing");
        check("R5 glitch raised no error", err_rises - rises0, 0);
    endtask

    task automatic test_rx_overflow();
        for (int i = 0; i < 5; i++) send_byte(8'h10 + 8'(i), 1'b1);
        check("R9 head is oldest after overflow", rx_head, 8'h10);
    endtask

    task automatic test_tx_full();
        for (int i = 0; i < 4; i++) begin
            pulse_req();
            repeat (6) @(negedge clk);
        end
        check("R10 refused request keeps head", rx_head, 8'h13);
        expect_echo(8'h11, "R10 first");
        expect_echo(8'h12, "R10 second");
        expect_echo(8'h13, "R10 third");
        pulse_req();
        expect_echo(8'h14, "R10 refused byte kept");
        pulse_req();
        expect_no_echo("R9 fifth byte dropped");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;
        test_reset();
        test_echo_basic();
        test_wrap();
        test_bit_time();
        test_empty_req();
        test_frame_err();
        test_glitch();
        test_rx_overflow();
        test_tx_full();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule